// File: doc/BRIEF.md
# Maintenance Packet Hop-Count Handler

This block sits in the inbound path of a switch port and handles maintenance packets. Each packet header arrives as one parallel word under a valid/ready handshake. The block sorts each packet by its hop count. A packet with a nonzero hop count passes through: its hop count drops by one, its CRC is computed again, and it goes to the fabric-side output. A packet with a zero hop count is consumed locally. For a read or write request, the block issues a single-word (4-byte) access on the internal register bus. When the bus completes the access, the block builds a response with a fresh CRC and places it on the response output, which feeds the outbound side of the same port.

The number of register accesses in flight is capped by a parameter. A context FIFO of that depth holds the pending requests, and responses leave in request order. A local read or write that arrives while the FIFO is full never reaches the bus. It is answered at once with a retry response. Other zero-hop packet types are accepted and dropped.

The packet word is 112 bits. From the top bit down it holds: hop [111:104], type [103:100], status [99:96], transaction tag [95:88], destination ID [87:72], source ID [71:56], register offset [55:32] and data [31:0]. Type codes: 0 read request, 1 write request, 2 read response, 3 write response, 4 port-write. Status codes: 0 done, 3 retry.

Top module: `mhc_maint_handler`

## Requirements
- R1: After reset, fwd_valid and rsp_valid are low and rb_rsp_ready is low, because no access is outstanding.
- R2: A packet accepted with a nonzero hop count appears on fwd_pkt in the next cycle. The hop field is one less, so hop 1 becomes 0 and hop 0xFF becomes 0xFE. Every other field is unchanged, whatever the type.
- R3: fwd_crc is a CRC-16 over the 112-bit forwarded word, taken most significant bit first. The polynomial is 0x1021 and the register starts at 0xFFFF.
- R4: A zero-hop read (type 0) or write (type 1) that arrives while fewer than the maximum accesses are pending raises rb_req_valid in the same cycle. On that access, rb_req_write is 1 for a write, rb_req_addr is offset[23:2] and rb_req_wdata is the data field. The packet is accepted when rb_req_ready is high. A packet with a nonzero hop never drives the register bus.
- R5: The cycle after a register-bus completion handshake, rsp_pkt holds a response to the oldest pending request. Its hop is 0xFF, status is 0, the tag is echoed, destination ID is the request's source ID and source ID is the request's destination ID, and offset is 0. A read returns type 2 with the read data. A write returns type 3 with data 0.
- R6: rsp_crc uses the same CRC-16 as R3, taken over the 112-bit response word.
- R7: A zero-hop read or write that arrives while the maximum number of accesses is pending produces no bus access. The next cycle it yields a response with status 3, data 0, swapped IDs, the echoed tag, and type 2 or 3 to match the request.
- R8: An access stops counting as pending in the cycle its response is queued. After that, a new request goes to the bus again.
- R9: A zero-hop packet of any type other than 0 or 1 is accepted and produces nothing on the fabric, response or register-bus side.
- R10: While fwd_valid or rsp_valid is high and its ready is low, the packet and CRC on that output stay unchanged. A forward-bound input is not accepted while the fabric output is held this way.
- R11: A bus completion takes priority over a retry in the same cycle. rb_rsp_ready is low while the response output is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inbound packet valid |
| in_ready | output | 1 | Inbound packet accepted this cycle |
| in_pkt | input | 112 | Inbound packet word |
| fwd_valid | output | 1 | Forwarded packet valid |
| fwd_ready | input | 1 | Fabric accepts the forwarded packet |
| fwd_pkt | output | 112 | Forwarded packet word, hop decremented |
| fwd_crc | output | 16 | CRC of the forwarded word |
| rsp_valid | output | 1 | Response packet valid |
| rsp_ready | input | 1 | Outbound side accepts the response |
| rsp_pkt | output | 112 | Response packet word |
| rsp_crc | output | 16 | CRC of the response word |
| rb_req_valid | output | 1 | Register access request |
| rb_req_ready | input | 1 | Register bus takes the request |
| rb_req_write | output | 1 | 1 for a write access |
| rb_req_addr | output | 22 | Word address of the access |
| rb_req_wdata | output | 32 | Write data |
| rb_rsp_valid | input | 1 | Register bus completion |
| rb_rsp_ready | output | 1 | Completion taken this cycle |
| rb_rsp_rdata | input | 32 | Read data of the completion |

## Verification
The bench builds the handler with a maximum of two outstanding accesses. This makes the retry boundary reachable after just two unanswered requests. It also brings into reach the cycle where a completion and a would-be retry collide, and the point where one completion reopens the bus to the next request. The fabric and response readies and the bus completions are driven by hand, so backpressure on both outputs can be held for several cycles.

// File: rtl/mhc_pkg.sv
package mhc_pkg;

    parameter int HOP_W  = 8;
    parameter int TT_W   = 4;
    parameter int ST_W   = 4;
    parameter int TID_W  = 8;
    parameter int ID_W   = 16;
    parameter int OFF_W  = 24;
    parameter int DATA_W = 32;
    parameter int CRC_W  = 16;

    localparam int PKT_W   = HOP_W + TT_W + ST_W + TID_W + 2 * ID_W + OFF_W + DATA_W;
    localparam int WADDR_W = OFF_W - 2;

    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

    localparam logic [HOP_W-1:0] RSP_HOP   = '1;
    localparam logic [ST_W-1:0]  ST_DONE   = 4'h0;
    localparam logic [ST_W-1:0]  ST_RETRY  = 4'h3;

    typedef enum logic [TT_W-1:0] {
        TT_RD_REQ  = 4'h0,
        TT_WR_REQ  = 4'h1,
        TT_RD_RSP  = 4'h2,
        TT_WR_RSP  = 4'h3,
        TT_PORT_WR = 4'h4
    } mhc_ttype_e;

    typedef struct packed {
        logic [HOP_W-1:0]  hop;
        logic [TT_W-1:0]   ttype;
        logic [ST_W-1:0]   status;
        logic [TID_W-1:0]  tid;
        logic [ID_W-1:0]   dst;
        logic [ID_W-1:0]   src;
        logic [OFF_W-1:0]  offset;
        logic [DATA_W-1:0] data;
    } mhc_pkt_t;

    // Saved per pending access; IDs kept as received, swapped when the response is built
    typedef struct packed {
        logic              is_write;
        logic [TID_W-1:0]  tid;
        logic [ID_W-1:0]   dst;
        logic [ID_W-1:0]   src;
    } mhc_ctx_t;

    function automatic logic [CRC_W-1:0] mhc_crc16(input mhc_pkt_t p);
        logic [PKT_W-1:0] bits;
        logic [CRC_W-1:0] c;
        logic             fb;
        bits = p;
        c    = CRC_SEED;
        for (int i = PKT_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ bits[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/mhc_ctx_fifo.sv
module mhc_ctx_fifo
    import mhc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  mhc_ctx_t push_ctx,
    input  logic     pop,
    output mhc_ctx_t head,
    output logic     full,
    output logic     empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    mhc_ctx_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_ctx;
    end

    assign head  = mem[rd_ptr];
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);

endmodule

// File: rtl/mhc_out_slot.sv
module mhc_out_slot
    import mhc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  mhc_pkt_t         load_pkt,
    output logic             free,
    output logic             out_valid,
    input  logic             out_ready,
    output mhc_pkt_t         out_pkt,
    output logic [CRC_W-1:0] out_crc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pkt   <= '0;
            out_crc   <= '0;
        end else begin
            if (load) begin
                out_valid <= 1'b1;
                out_pkt   <= load_pkt;
                out_crc   <= mhc_crc16(load_pkt);
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign free = !out_valid || out_ready;

endmodule

// File: rtl/mhc_rsp_build.sv
module mhc_rsp_build
    import mhc_pkg::*;
(
    input  mhc_ctx_t          ctx,
    input  logic              is_retry,
    input  logic [DATA_W-1:0] rdata,
    output mhc_pkt_t          rsp
);

    always_comb begin
        rsp.hop    = RSP_HOP;
        rsp.ttype  = ctx.is_write ? TT_WR_RSP : TT_RD_RSP;
        rsp.status = is_retry ? ST_RETRY : ST_DONE;
        rsp.tid    = ctx.tid;
        rsp.dst    = ctx.src;
        rsp.src    = ctx.dst;
        rsp.offset = '0;
        rsp.data   = (is_retry || ctx.is_write) ? '0 : rdata;
    end

endmodule

// File: rtl/mhc_maint_handler.sv
module mhc_maint_handler
    import mhc_pkg::*;
#(
    parameter int MAX_OUT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PKT_W-1:0]   in_pkt,
    output logic               fwd_valid,
    input  logic               fwd_ready,
    output logic [PKT_W-1:0]   fwd_pkt,
    output logic [CRC_W-1:0]   fwd_crc,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PKT_W-1:0]   rsp_pkt,
    output logic [CRC_W-1:0]   rsp_crc,
    output logic               rb_req_valid,
    input  logic               rb_req_ready,
    output logic               rb_req_write,
    output logic [WADDR_W-1:0] rb_req_addr,
    output logic [DATA_W-1:0]  rb_req_wdata,
    input  logic               rb_rsp_valid,
    output logic               rb_rsp_ready,
    input  logic [DATA_W-1:0]  rb_rsp_rdata
);

    mhc_pkt_t in_p;
    mhc_pkt_t fwd_next;
    mhc_pkt_t rsp_next;
    mhc_pkt_t fwd_s;
    mhc_pkt_t rsp_s;
    mhc_ctx_t in_ctx;
    mhc_ctx_t head_ctx;
    mhc_ctx_t build_ctx;

    logic is_local;
    logic is_rw;
    logic ctx_full;
    logic ctx_empty;
    logic fwd_free;
    logic rsp_free;
    logic fwd_load;
    logic rsp_load;
    logic issue;
    logic cpl;
    logic retry;

    assign in_p = mhc_pkt_t'(in_pkt);

    always_comb begin
        is_local = (in_p.hop == '0);
        is_rw    = (in_p.ttype == TT_RD_REQ) || (in_p.ttype == TT_WR_REQ);

        in_ctx.is_write = (in_p.ttype == TT_WR_REQ);
        in_ctx.tid      = in_p.tid;
        in_ctx.dst      = in_p.dst;
        in_ctx.src      = in_p.src;

        // Completions from the register bus own the response slot first
        rb_rsp_ready = rsp_free && !ctx_empty;
        cpl          = rb_rsp_valid && rb_rsp_ready;

        rb_req_valid = in_valid && is_local && is_rw && !ctx_full;
        rb_req_write = in_ctx.is_write;
        rb_req_addr  = in_p.offset[OFF_W-1:2];
        rb_req_wdata = in_p.data;
        issue        = rb_req_valid && rb_req_ready;

        retry    = in_valid && is_local && is_rw && ctx_full && rsp_free && !cpl;
        fwd_load = in_valid && !is_local && fwd_free;
        rsp_load = cpl || retry;

        if (!is_local)
            in_ready = fwd_free;
        else if (is_rw && !ctx_full)
            in_ready = rb_req_ready;
        else if (is_rw)
            in_ready = rsp_free && !cpl;
        else
            in_ready = 1'b1;

        fwd_next     = in_p;
        fwd_next.hop = in_p.hop - HOP_W'(1);

        build_ctx = cpl ? head_ctx : in_ctx;
    end

    mhc_ctx_fifo #(
        .DEPTH (MAX_OUT)
    ) u_ctx (
        .clk      (clk),
        .rst      (rst),
        .push     (issue),
        .push_ctx (in_ctx),
        .pop      (cpl),
        .head     (head_ctx),
        .full     (ctx_full),
        .empty    (ctx_empty)
    );

    mhc_rsp_build u_build (
        .ctx      (build_ctx),
        .is_retry (!cpl),
        .rdata    (rb_rsp_rdata),
        .rsp      (rsp_next)
    );

    mhc_out_slot u_fwd_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (fwd_load),
        .load_pkt  (fwd_next),
        .free      (fwd_free),
        .out_valid (fwd_valid),
        .out_ready (fwd_ready),
        .out_pkt   (fwd_s),
        .out_crc   (fwd_crc)
    );

    mhc_out_slot u_rsp_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (rsp_load),
        .load_pkt  (rsp_next),
        .free      (rsp_free),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_pkt   (rsp_s),
        .out_crc   (rsp_crc)
    );

    assign fwd_pkt = fwd_s;
    assign rsp_pkt = rsp_s;

endmodule

// File: rtl/mhc_maint_handler_chk.sv
module mhc_maint_handler_chk
    import mhc_pkg::*;
#(
    parameter int MAX_OUT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PKT_W-1:0] in_pkt,
    input logic             fwd_valid,
    input logic             fwd_ready,
    input logic [PKT_W-1:0] fwd_pkt,
    input logic [CRC_W-1:0] fwd_crc,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PKT_W-1:0] rsp_pkt,
    input logic [CRC_W-1:0] rsp_crc,
    input logic             rb_req_valid,
    input logic             rb_req_ready,
    input logic             rb_rsp_valid,
    input logic             rb_rsp_ready
);

    localparam int PEND_W = $clog2(MAX_OUT + 2) + 1;

    mhc_pkt_t          ip;
    mhc_pkt_t          rp;
    logic [PEND_W-1:0] pend;

    assign ip = mhc_pkt_t'(in_pkt);
    assign rp = mhc_pkt_t'(rsp_pkt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            case ({rb_req_valid && rb_req_ready, rb_rsp_valid && rb_rsp_ready})
                2'b10:   pend <= pend + PEND_W'(1);
                2'b01:   pend <= pend - PEND_W'(1);
                default: pend <= pend;
            endcase
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !fwd_valid && !rsp_valid);

    // R2
    fwd_decr_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (ip.hop != '0) |=>
        fwd_valid && (fwd_pkt == {$past(ip.hop) - HOP_W'(1), $past(in_pkt[PKT_W-HOP_W-1:0])}));

    // R3
    fwd_crc_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> fwd_crc == mhc_crc16(mhc_pkt_t'(fwd_pkt)));

    // R4
    fwd_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (ip.hop != '0) |-> !rb_req_valid);

    // R5
    rsp_type_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rp.ttype == TT_RD_RSP) || (rp.ttype == TT_WR_RSP));

    // R6
    rsp_crc_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_crc == mhc_crc16(rp));

    // R7
    full_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == PEND_W'(MAX_OUT)) |-> !rb_req_valid);

    // R8
    pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pend <= PEND_W'(MAX_OUT));

    // R10
    fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_pkt) && $stable(fwd_crc));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pkt) && $stable(rsp_crc));

    // R11
    cpl_slot_chk: assert property (@(posedge clk) disable iff (rst)
        rb_rsp_ready |-> !rsp_valid || rsp_ready);

endmodule

bind mhc_maint_handler mhc_maint_handler_chk #(
    .MAX_OUT (MAX_OUT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_pkt       (in_pkt),
    .fwd_valid    (fwd_valid),
    .fwd_ready    (fwd_ready),
    .fwd_pkt      (fwd_pkt),
    .fwd_crc      (fwd_crc),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_pkt      (rsp_pkt),
    .rsp_crc      (rsp_crc),
    .rb_req_valid (rb_req_valid),
    .rb_req_ready (rb_req_ready),
    .rb_rsp_valid (rb_rsp_valid),
    .rb_rsp_ready (rb_rsp_ready)
);

// File: tb/mhc_maint_handler_tb.sv
`timescale 1ns/1ps
module mhc_maint_handler_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [111:0] in_pkt = '0;
    logic         fwd_valid;
    logic         fwd_ready = 1'b1;
    logic [111:0] fwd_pkt;
    logic [15:0]  fwd_crc;
    logic         rsp_valid;
    logic         rsp_ready = 1'b1;
    logic [111:0] rsp_pkt;
    logic [15:0]  rsp_crc;
    logic         rb_req_valid;
    logic         rb_req_ready = 1'b1;
    logic         rb_req_write;
    logic [21:0]  rb_req_addr;
    logic [31:0]  rb_req_wdata;
    logic         rb_rsp_valid = 1'b0;
    logic         rb_rsp_ready;
    logic [31:0]  rb_rsp_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mhc_maint_handler #(.MAX_OUT(2)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_pkt(fwd_pkt), .fwd_crc(fwd_crc),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pkt(rsp_pkt), .rsp_crc(rsp_crc),
        .rb_req_valid(rb_req_valid), .rb_req_ready(rb_req_ready), .rb_req_write(rb_req_write),
        .rb_req_addr(rb_req_addr), .rb_req_wdata(rb_req_wdata),
        .rb_rsp_valid(rb_rsp_valid), .rb_rsp_ready(rb_rsp_ready), .rb_rsp_rdata(rb_rsp_rdata)
    );

    // Forwarding vectors: {packet word, expected hop after forwarding}
    localparam logic [119:0] FWD_VEC [6] = '{
        {8'h01, 4'h0, 4'h0, 8'h11, 16'h0102, 16'h0304, 24'h000010, 32'hDEADBEEF, 8'h00},
        {8'hFF, 4'h1, 4'h0, 8'h12, 16'hFFFF, 16'h0000, 24'hFFFFFC, 32'h01234567, 8'hFE},
        {8'h10, 4'h4, 4'h0, 8'h13, 16'h5A5A, 16'hA5A5, 24'h123456, 32'h00000000, 8'h0F},
        {8'h02, 4'h2, 4'h0, 8'h14, 16'h0001, 16'h8000, 24'h000000, 32'hFFFFFFFF, 8'h01},
        {8'h80, 4'h3, 4'h3, 8'h15, 16'h1357, 16'h2468, 24'h000004, 32'h0F0F0F0F, 8'h7F},
        {8'h07, 4'hA, 4'h5, 8'hFF, 16'hBEEF, 16'hCAFE, 24'h800001, 32'h80000001, 8'h06}
    };

    function automatic logic [111:0] mk(input logic [7:0] hop, input logic [3:0] tt,
                                        input logic [3:0] st, input logic [7:0] tid,
                                        input logic [15:0] dst, input logic [15:0] src,
                                        input logic [23:0] off, input logic [31:0] d);
        return {hop, tt, st, tid, dst, src, off, d};
    endfunction

    function automatic logic [15:0] ref_crc(input logic [111:0] w);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 111; i >= 0; i--) begin
            logic fb;
            fb = c[15] ^ w[i];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [111:0] p);
        @(negedge clk);
        in_pkt   = p;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic complete(input logic [31:0] d);
        @(negedge clk);
        rb_rsp_valid = 1'b1;
        rb_rsp_rdata = d;
        while (!rb_rsp_ready) @(negedge clk);
        @(negedge clk);
        rb_rsp_valid = 1'b0;
    endtask

    task automatic chk_rsp(input string req, input logic [111:0] exp);
        chk(req, "rsp_valid", rsp_valid, 1'b1);
        chk(req, "rsp_pkt", rsp_pkt, exp);
        chk(req, "rsp_crc", rsp_crc, ref_crc(exp));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [111:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "fwd_valid", fwd_valid, 1'b0);
        chk("R1", "rsp_valid", rsp_valid, 1'b0);
        chk("R1", "rb_rsp_ready", rb_rsp_ready, 1'b0);

        // R2 / R3 table-driven forwarding
        for (int k = 0; k < 6; k++) begin
            logic [111:0] p;
            logic [7:0]   eh;
            logic [111:0] ex;
            p  = FWD_VEC[k][119:8];
            eh = FWD_VEC[k][7:0];
            push(p);
            ex = {eh, p[103:0]};
            chk("R2", "fwd_valid", fwd_valid, 1'b1);
            chk("R2", "fwd_pkt", fwd_pkt, ex);
            chk("R3", "fwd_crc", fwd_crc, ref_crc(ex));
            chk("R2", "rsp_valid", rsp_valid, 1'b0);
        end

        // R4 / R5 / R6 local read
        @(negedge clk);
        in_pkt   = mk(8'h00, 4'h0, 4'h0, 8'h21, 16'h1234, 16'hABCD, 24'h000107, 32'h0);
        in_valid = 1'b1;
        #1;
        chk("R4", "rb_req_valid", rb_req_valid, 1'b1);
        chk("R4", "rb_req_write", rb_req_write, 1'b0);
        chk("R4", "rb_req_addr", rb_req_addr, 22'h000041);
        chk("R4", "in_ready", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4", "fwd_valid", fwd_valid, 1'b0);
        chk("R4", "rsp_valid before completion", rsp_valid, 1'b0);
        complete(32'hCAFEF00D);
        chk_rsp("R5", mk(8'hFF, 4'h2, 4'h0, 8'h21, 16'hABCD, 16'h1234, 24'h0, 32'hCAFEF00D));

        // R4 / R5 / R6 local write
        @(negedge clk);
        in_pkt   = mk(8'h00, 4'h1, 4'h0, 8'h22, 16'h0042, 16'h0777, 24'h00ABCC, 32'h13579BDF);
        in_valid = 1'b1;
        #1;
        chk("R4", "rb_req_write", rb_req_write, 1'b1);
        chk("R4", "rb_req_addr", rb_req_addr, 22'h002AF3);
        chk("R4", "rb_req_wdata", rb_req_wdata, 32'h13579BDF);
        @(negedge clk);
        in_valid = 1'b0;
        complete(32'h55555555);
        chk_rsp("R6", mk(8'hFF, 4'h3, 4'h0, 8'h22, 16'h0777, 16'h0042, 24'h0, 32'h0));

        // R7 / R8 outstanding limit and retry
        push(mk(8'h00, 4'h0, 4'h0, 8'h01, 16'h0010, 16'h0020, 24'h000040, 32'h0));
        push(mk(8'h00, 4'h0, 4'h0, 8'h02, 16'h0011, 16'h0021, 24'h000044, 32'h0));
        @(negedge clk);
        in_pkt   = mk(8'h00, 4'h0, 4'h0, 8'h03, 16'h0030, 16'h0040, 24'h000048, 32'h77);
        in_valid = 1'b1;
        #1;
        chk("R7", "rb_req_valid when full", rb_req_valid, 1'b0);
        chk("R7", "in_ready when full", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk_rsp("R7", mk(8'hFF, 4'h2, 4'h3, 8'h03, 16'h0040, 16'h0030, 24'h0, 32'h0));
        push(mk(8'h00, 4'h1, 4'h0, 8'h04, 16'h0050, 16'h0060, 24'h00004C, 32'h99));
        chk_rsp("R7", mk(8'hFF, 4'h3, 4'h3, 8'h04, 16'h0060, 16'h0050, 24'h0, 32'h0));
        complete(32'h11111111);
        chk_rsp("R5", mk(8'hFF, 4'h2, 4'h0, 8'h01, 16'h0020, 16'h0010, 24'h0, 32'h11111111));
        complete(32'h22222222);
        chk_rsp("R5", mk(8'hFF, 4'h2, 4'h0, 8'h02, 16'h0021, 16'h0011, 24'h0, 32'h22222222));
        @(negedge clk);
        in_pkt   = mk(8'h00, 4'h0, 4'h0, 8'h05, 16'h0070, 16'h0080, 24'h000100, 32'h0);
        in_valid = 1'b1;
        #1;
        chk("R8", "rb_req_valid after drain", rb_req_valid, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        complete(32'h55AA55AA);
        chk_rsp("R8", mk(8'hFF, 4'h2, 4'h0, 8'h05, 16'h0080, 16'h0070, 24'h0, 32'h55AA55AA));

        // R11 completion beats retry; R8 slot reopens the same cycle
        push(mk(8'h00, 4'h0, 4'h0, 8'h08, 16'h0808, 16'h8080, 24'h0, 32'h0));
        push(mk(8'h00, 4'h0, 4'h0, 8'h09, 16'h0909, 16'h9090, 24'h0, 32'h0));
        @(negedge clk);
        rb_rsp_valid = 1'b1;
        rb_rsp_rdata = 32'h88888888;
        in_pkt   = mk(8'h00, 4'h0, 4'h0, 8'h0A, 16'h0A0A, 16'h0B0B, 24'h0, 32'h0);
        in_valid = 1'b1;
        #1;
        chk("R11", "in_ready during completion", in_ready, 1'b0);
        chk("R11", "rb_rsp_ready", rb_rsp_ready, 1'b1);
        @(negedge clk);
        rb_rsp_valid = 1'b0;
        #1;
        chk_rsp("R11", mk(8'hFF, 4'h2, 4'h0, 8'h08, 16'h8080, 16'h0808, 24'h0, 32'h88888888));
        chk("R8", "rb_req_valid after completion", rb_req_valid, 1'b1);
        chk("R8", "in_ready after completion", in_ready, 1'b1);
        @(negedge clk);
        in_valid  = 1'b0;
        rsp_ready = 1'b0;
        complete(32'h99999999);
        chk_rsp("R5", mk(8'hFF, 4'h2, 4'h0, 8'h09, 16'h9090, 16'h0909, 24'h0, 32'h99999999));
        @(negedge clk);
        rb_rsp_valid = 1'b1;
        rb_rsp_rdata = 32'hAAAAAAAA;
        #1;
        chk("R11", "rb_rsp_ready while held", rb_rsp_ready, 1'b0);
        chk("R10", "rsp_pkt held", rsp_pkt,
            mk(8'hFF, 4'h2, 4'h0, 8'h09, 16'h9090, 16'h0909, 24'h0, 32'h99999999));
        @(negedge clk);
        rsp_ready = 1'b1;
        #1;
        chk("R11", "rb_rsp_ready once drained", rb_rsp_ready, 1'b1);
        @(negedge clk);
        rb_rsp_valid = 1'b0;
        chk_rsp("R11", mk(8'hFF, 4'h2, 4'h0, 8'h0A, 16'h0B0B, 16'h0A0A, 24'h0, 32'hAAAAAAAA));

        // R9 zero-hop non-request types are dropped
        @(negedge clk);
        in_pkt   = mk(8'h00, 4'h4, 4'h0, 8'h33, 16'h0001, 16'h0002, 24'h000010, 32'h12345678);
        in_valid = 1'b1;
        #1;
        chk("R9", "in_ready port-write", in_ready, 1'b1);
        chk("R9", "rb_req_valid port-write", rb_req_valid, 1'b0);
        @(negedge clk);
        in_pkt = mk(8'h00, 4'h2, 4'h0, 8'h34, 16'h0003, 16'h0004, 24'h0, 32'h1);
        #1;
        chk("R9", "rb_req_valid read response", rb_req_valid, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "fwd_valid", fwd_valid, 1'b0);
        chk("R9", "rsp_valid", rsp_valid, 1'b0);
        @(negedge clk);
        chk("R9", "rsp_valid later", rsp_valid, 1'b0);

        // R10 fabric backpressure
        fwd_ready = 1'b0;
        push(mk(8'h05, 4'h0, 4'h0, 8'h41, 16'h1111, 16'h2222, 24'h000020, 32'hA0A0A0A0));
        e = mk(8'h04, 4'h0, 4'h0, 8'h41, 16'h1111, 16'h2222, 24'h000020, 32'hA0A0A0A0);
        chk("R10", "fwd_valid", fwd_valid, 1'b1);
        @(negedge clk);
        in_pkt   = mk(8'h09, 4'h1, 4'h0, 8'h42, 16'h3333, 16'h4444, 24'h000024, 32'hB0B0B0B0);
        in_valid = 1'b1;
        #1;
        chk("R10", "in_ready while held", in_ready, 1'b0);
        @(negedge clk);
        chk("R10", "fwd_pkt held", fwd_pkt, e);
        chk("R10", "fwd_crc held", fwd_crc, ref_crc(e));
        fwd_ready = 1'b1;
        #1;
        chk("R10", "in_ready on release", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        e = mk(8'h08, 4'h1, 4'h0, 8'h42, 16'h3333, 16'h4444, 24'h000024, 32'hB0B0B0B0);
        chk("R2", "fwd_pkt after release", fwd_pkt, e);
        chk("R3", "fwd_crc after release", fwd_crc, ref_crc(e));

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule